// File: doc/BRIEF.md
# Interval Timer Count Latch Readout

This block is the read side of a three-channel interval timer. It sits between a byte-wide port bus and three free-running 16-bit down-counters. Software writes commands to a control port. Each counter has a data port, and software reads its counter through that port one byte at a time.

A latch command freezes a snapshot of one counter in that counter's own hold register while the counter keeps running. The snapshot stays until software has read every byte that the counter's access format calls for. When no snapshot is held, a read returns the live count. A format command sets whether a counter is read as its low byte, its high byte, or its low byte followed by its high byte. The same command drops any snapshot and restarts the byte sequence. A gate bit stops counter 2 so that its live value can be read steadily.

Requests arrive on a valid/ready channel. A read is answered on a second valid/ready channel one cycle after it is accepted. While a read answer waits for the consumer, the request side deasserts ready, so at most one answer is ever pending. The read-back command body is handled elsewhere. This block only flags it with a one-cycle strobe.

Top module: `tlr_latch_readout`

## Requirements
- R1: Address 40h, 41h and 42h are the data ports of counters 0, 1 and 2. Address 43h is the command port. Bit 0 of address 61h is the counter 2 gate and can be written and read. A read of any other address returns 00h.
- R2: In a command byte, bits 7:6 select the counter (00, 01, 10). A latch command has bits 5:4 equal to 00 and bits 3:0 equal to 0000. A latch command with any of bits 3:0 set is ignored.
- R3: A latch command stores the selected counter's count at the accepting clock edge. The counter keeps decrementing, and later reads return bytes of the stored value.
- R4: A latch command to a counter that already holds an unread snapshot is ignored. The stored value stays that of the first command.
- R5: The snapshot is released once it has been fully read: after one read in the single-byte formats, and after the second read in the two-byte format. The next read returns live data.
- R6: A command with bits 5:4 not 00 sets the selected counter's format (01 low only, 10 high only, 11 low then high). It also drops that counter's snapshot and makes the next read return the low byte.
- R7: In format 11, the first read returns the low byte and the second returns the high byte. Each counter keeps its own byte position, so reads of different counters may be interleaved.
- R8: With no snapshot held, a data-port read returns the byte of the live count chosen by the format and the byte position.
- R9: A command with bits 7:6 equal to 11 latches nothing and reprograms nothing. It raises rbk_strobe for one cycle, with rbk_cmd holding command bits 5:0.
- R10: While the gate bit is 0, counter 2 does not decrement and counters 0 and 1 continue. The gate resets to 1.
- R11: A request is taken when req_valid and req_ready are both high. A read makes rsp_valid high in the next cycle. rsp_data stays stable until rsp_ready is seen, and req_ready stays low while rsp_valid is high. Writes produce no response.
- R12: After reset, every counter is 0000h with format 11, no snapshot and the low byte next, and the gate is 1. A counter decrements, wrapping modulo 2^16, on each cycle in which cnt_tick is high and the counter is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_tick | input | 1 | Count enable for all counters |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready, low while a response is pending |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 8 | Port address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response consumed |
| rsp_data | output | 8 | Read response byte |
| rbk_strobe | output | 1 | One-cycle flag for a read-back command |
| rbk_cmd | output | 6 | Bits 5:0 of the last read-back command |

## Verification
Every counter is taken through every access format, reading a snapshot while the counter keeps moving. Because the stored and live values then differ, a failure to hold the snapshot or a failure to release it shows up as a wrong byte. Interleaved two-byte reads of two latched counters separate per-counter byte positions from a shared one. Repeated latches, reprogramming in the middle of a snapshot or in the middle of a byte pair, non-zero reserved bits and the read-back selector each check that a command changes only what it should. With the gate low and the other counters still ticking, the bench tells a stopped counter 2 from stopped counters in general. A held-off response, with a competing request pending, shows whether back-pressure drops or accepts that request.

// File: rtl/tlr_pkg.sv
package tlr_pkg;
  localparam int NCH = 3;
  localparam int CW = 16;
  localparam int BW = 8;
  localparam logic [7:0] DATA_BASE = 8'h40;
  localparam logic [7:0] CTRL_ADDR = 8'h43;
  localparam logic [7:0] GATE_ADDR = 8'h61;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_WORD  = 2'b11
  } acc_t;
endpackage

// File: rtl/tlr_downcnt.sv
module tlr_downcnt #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          enable,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else if (tick && enable) count <= count - 1'b1;
  end
endmodule

// File: rtl/tlr_cmd_dec.sv
module tlr_cmd_dec
  import tlr_pkg::*;
#(
  parameter int N = NCH
) (
  input  logic         ctl_wr,
  input  logic [7:0]   wdata,
  output logic [N-1:0] latch_req,
  output logic [N-1:0] prog_req,
  output acc_t         new_acc,
  output logic         rbk_hit
);
  logic [1:0] sel;
  logic       is_latch;
  logic       rsv_clear;

  assign sel       = wdata[7:6];
  assign is_latch  = (wdata[5:4] == ACC_LATCH);
  assign rsv_clear = (wdata[3:0] == 4'h0);
  assign new_acc   = acc_t'(wdata[5:4]);
  assign rbk_hit   = ctl_wr && (sel == 2'b11);

  for (genvar i = 0; i < N; i++) begin : g_sel
    logic hit;
    assign hit          = ctl_wr && (sel == 2'(i));
    assign latch_req[i] = hit && is_latch && rsv_clear;
    assign prog_req[i]  = hit && !is_latch;
  end
endmodule

// File: rtl/tlr_chan_rd.sv
module tlr_chan_rd
  import tlr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic          latch_req,
  input  logic          prog_req,
  input  acc_t          new_acc,
  input  logic          rd_req,
  output logic [7:0]    rd_byte,
  output logic          latched,
  output logic [CW-1:0] hold
);
  acc_t          acc;
  logic          ptr_hi;
  logic [CW-1:0] src;
  logic          hi_sel;
  logic          last_byte;

  assign src       = latched ? hold : count;
  assign hi_sel    = (acc == ACC_HI) || ((acc == ACC_WORD) && ptr_hi);
  assign rd_byte   = hi_sel ? src[CW-1 -: 8] : src[7:0];
  assign last_byte = (acc != ACC_WORD) || ptr_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc     <= ACC_WORD;
      ptr_hi  <= 1'b0;
      latched <= 1'b0;
      hold    <= '0;
    end else if (prog_req) begin
      acc     <= new_acc;
      ptr_hi  <= 1'b0;
      latched <= 1'b0;
    end else begin
      if (rd_req) begin
        if (acc == ACC_WORD) ptr_hi <= ~ptr_hi;
        if (last_byte) latched <= 1'b0;
      end
      if (latch_req && !latched) begin
        hold    <= count;
        latched <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tlr_latch_readout.sv
module tlr_latch_readout
  import tlr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cnt_tick,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_write,
  input  logic [7:0] req_addr,
  input  logic [7:0] req_wdata,
  output logic       rsp_valid,
  input  logic       rsp_ready,
  output logic [7:0] rsp_data,
  output logic       rbk_strobe,
  output logic [5:0] rbk_cmd
);
  logic                     take;
  logic                     rd_take;
  logic                     ctl_wr;
  logic                     gate_wr;
  logic                     gate2;
  logic [NCH-1:0]           latch_req;
  logic [NCH-1:0]           prog_req;
  logic [NCH-1:0]           rd_ch;
  logic [NCH-1:0]           ch_latched;
  logic [NCH-1:0][CW-1:0]   ch_hold;
  logic [NCH-1:0][CW-1:0]   cnt;
  logic [NCH-1:0][7:0]      ch_byte;
  acc_t                     new_acc;
  logic                     rbk_hit;
  logic [7:0]               rd_mux;

  assign req_ready = !rsp_valid;
  assign take      = req_valid && req_ready;
  assign rd_take   = take && !req_write;
  assign ctl_wr    = take && req_write && (req_addr == CTRL_ADDR);
  assign gate_wr   = take && req_write && (req_addr == GATE_ADDR);

  tlr_cmd_dec #(.N(NCH)) u_dec (
    .ctl_wr    (ctl_wr),
    .wdata     (req_wdata),
    .latch_req (latch_req),
    .prog_req  (prog_req),
    .new_acc   (new_acc),
    .rbk_hit   (rbk_hit)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic en;
    if (i == 2) begin : g_gated
      assign en = gate2;
    end else begin : g_free
      assign en = 1'b1;
    end

    assign rd_ch[i] = rd_take && (req_addr == 8'(DATA_BASE + i));

    tlr_downcnt #(.CW(CW)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (cnt_tick),
      .enable (en),
      .count  (cnt[i])
    );

    tlr_chan_rd #(.CW(CW)) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .count     (cnt[i]),
      .latch_req (latch_req[i]),
      .prog_req  (prog_req[i]),
      .new_acc   (new_acc),
      .rd_req    (rd_ch[i]),
      .rd_byte   (ch_byte[i]),
      .latched   (ch_latched[i]),
      .hold      (ch_hold[i])
    );
  end

  always_comb begin
    rd_mux = 8'h00;
    if (req_addr == GATE_ADDR) rd_mux = {7'b0, gate2};
    for (int i = 0; i < NCH; i++) begin
      if (req_addr == 8'(DATA_BASE + i)) rd_mux = ch_byte[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= 8'h00;
    end else if (rd_take) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) gate2 <= 1'b1;
    else if (gate_wr) gate2 <= req_wdata[0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rbk_strobe <= 1'b0;
      rbk_cmd    <= 6'h00;
    end else begin
      rbk_strobe <= rbk_hit;
      if (rbk_hit) rbk_cmd <= req_wdata[5:0];
    end
  end
endmodule

// File: rtl/tlr_latch_readout_chk.sv
module tlr_latch_readout_chk
  import tlr_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_ready,
  input logic                   req_write,
  input logic [7:0]             req_addr,
  input logic [7:0]             req_wdata,
  input logic                   rsp_valid,
  input logic                   rsp_ready,
  input logic [7:0]             rsp_data,
  input logic                   rbk_strobe,
  input logic                   gate2,
  input logic [NCH-1:0]         ch_latched,
  input logic [NCH-1:0][CW-1:0] ch_hold,
  input logic [NCH-1:0][CW-1:0] cnt
);
  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  assert_rd_answer_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_write |=> rsp_valid);

  assert_rsp_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(req_valid && req_ready && !req_write));

  assert_rbk_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rbk_strobe |-> $past(req_valid && req_ready && req_write &&
                         req_addr == CTRL_ADDR && req_wdata[7:6] == 2'b11));

  assert_gate_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(gate2) |-> $stable(cnt[2]));

  for (genvar i = 0; i < NCH; i++) begin : g_hold
    assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ch_latched[i] && $past(ch_latched[i]) |-> $stable(ch_hold[i]));
  end
endmodule

bind tlr_latch_readout tlr_latch_readout_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_write  (req_write),
  .req_addr   (req_addr),
  .req_wdata  (req_wdata),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_data   (rsp_data),
  .rbk_strobe (rbk_strobe),
  .gate2      (gate2),
  .ch_latched (ch_latched),
  .ch_hold    (ch_hold),
  .cnt        (cnt)
);

// File: tb/tb_tlr_latch_readout.sv
module tb_tlr_latch_readout;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_tick = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_write = 1'b0;
  logic [7:0] req_addr = 8'h00;
  logic [7:0] req_wdata = 8'h00;
  logic       rsp_valid;
  logic       rsp_ready = 1'b0;
  logic [7:0] rsp_data;
  logic       rbk_strobe;
  logic [5:0] rbk_cmd;

  int checks = 0;
  int failures = 0;
  logic [15:0] exp_cnt [3];
  logic        gate_m = 1'b1;

  always #5 clk = ~clk;

  tlr_latch_readout dut (
    .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rbk_strobe(rbk_strobe), .rbk_cmd(rbk_cmd)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    cnt_tick = 1'b1;
    repeat (n) @(negedge clk);
    cnt_tick = 1'b0;
    exp_cnt[0] = exp_cnt[0] - 16'(n);
    exp_cnt[1] = exp_cnt[1] - 16'(n);
    if (gate_m) exp_cnt[2] = exp_cnt[2] - 16'(n);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    if (!rsp_valid) begin
      checks++; failures++;
      $display("FAIL R11 actual=rsp_valid 0 expected=1 addr=%h", a);
    end
    d = rsp_data;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  function automatic logic [7:0] pcmd(input int ch, input int f);
    return {2'(ch), 2'(f), 4'h0};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    logic [7:0]  b;
    logic [7:0]  b2;
    logic [15:0] s0;
    logic [15:0] s1;
    for (int i = 0; i < 3; i++) exp_cnt[i] = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state
    chk("R12 req_ready", 16'(req_ready), 16'h1);
    chk("R12 rsp_valid", 16'(rsp_valid), 16'h0);
    chk("R12 rbk_strobe", 16'(rbk_strobe), 16'h0);
    rd(8'h61, b); chk("R12 gate reset", 16'(b), 16'h01);
    rd(8'h40, b); rd(8'h40, b2); chk("R12 count0 word", {b2, b}, 16'h0000);
    ticks(1);
    rd(8'h41, b); rd(8'h41, b2); chk("R12 wrap", {b2, b}, 16'hFFFF);

    // R3/R5/R8 sweep: every counter, every format
    for (int ch = 0; ch < 3; ch++) begin
      for (int f = 1; f < 4; f++) begin
        logic [15:0] snap;
        wr(8'h43, pcmd(ch, f));
        ticks(5 + ch * 7 + f * 3);
        wr(8'h43, pcmd(ch, 0));
        snap = exp_cnt[ch];
        ticks(9);
        if (f == 1) begin
          rd(8'(8'h40 + ch), b); chk("R3 low only", 16'(b), 16'(snap[7:0]));
          rd(8'(8'h40 + ch), b); chk("R5 R8 live low", 16'(b), 16'(exp_cnt[ch][7:0]));
        end else if (f == 2) begin
          rd(8'(8'h40 + ch), b); chk("R3 high only", 16'(b), 16'(snap[15:8]));
          rd(8'(8'h40 + ch), b); chk("R5 R8 live high", 16'(b), 16'(exp_cnt[ch][15:8]));
        end else begin
          rd(8'(8'h40 + ch), b);
          rd(8'h61, b2); chk("R7 interleaved gate read", 16'(b2), 16'h01);
          rd(8'(8'h40 + ch), b2);
          chk("R3 R7 word", {b2, b}, snap);
          rd(8'(8'h40 + ch), b); rd(8'(8'h40 + ch), b2);
          chk("R5 R8 live word", {b2, b}, exp_cnt[ch]);
        end
      end
    end

    // R7 interleaved two-byte reads of two latched counters
    wr(8'h43, pcmd(0, 3)); wr(8'h43, pcmd(1, 3));
    ticks(3); wr(8'h43, pcmd(0, 0)); s0 = exp_cnt[0];
    ticks(4); wr(8'h43, pcmd(1, 0)); s1 = exp_cnt[1];
    ticks(2);
    rd(8'h40, b); chk("R7 c0 low", 16'(b), 16'(s0[7:0]));
    rd(8'h41, b); chk("R7 c1 low", 16'(b), 16'(s1[7:0]));
    rd(8'h40, b); chk("R7 c0 high", 16'(b), 16'(s0[15:8]));
    rd(8'h41, b); chk("R7 c1 high", 16'(b), 16'(s1[15:8]));

    // R4 second latch ignored
    wr(8'h43, pcmd(2, 3));
    wr(8'h43, pcmd(2, 0)); s0 = exp_cnt[2];
    ticks(6); wr(8'h43, pcmd(2, 0)); ticks(2);
    rd(8'h42, b); rd(8'h42, b2); chk("R4 first snapshot kept", {b2, b}, s0);

    // R6 reprogram drops the snapshot
    wr(8'h43, pcmd(1, 0)); ticks(4);
    wr(8'h43, pcmd(1, 3));
    rd(8'h41, b); rd(8'h41, b2); chk("R6 latch cleared", {b2, b}, exp_cnt[1]);

    // R6 reprogram restarts the byte position
    wr(8'h43, pcmd(0, 3));
    rd(8'h40, b);
    wr(8'h43, pcmd(0, 3));
    rd(8'h40, b); chk("R6 pointer to low", 16'(b), 16'(exp_cnt[0][7:0]));
    rd(8'h40, b);

    // R2 reserved bits non-zero: no latch
    wr(8'h43, 8'h01); ticks(3);
    rd(8'h40, b); rd(8'h40, b2); chk("R2 reserved ignored", {b2, b}, exp_cnt[0]);

    // R9 read-back selector
    wr(8'h43, 8'hC5);
    chk("R9 strobe", 16'(rbk_strobe), 16'h1);
    chk("R9 cmd bits", 16'(rbk_cmd), 16'h05);
    @(negedge clk);
    chk("R9 strobe one cycle", 16'(rbk_strobe), 16'h0);
    ticks(3);
    rd(8'h40, b); rd(8'h41, b2); chk("R9 no latch c0 low", 16'(b), 16'(exp_cnt[0][7:0]));
    rd(8'h40, b); chk("R9 no reprogram c0 high", 16'(b), 16'(exp_cnt[0][15:8]));
    rd(8'h41, b);

    // R10 gate stops counter 2 only
    wr(8'h61, 8'h00); gate_m = 1'b0;
    ticks(10);
    rd(8'h42, b); rd(8'h42, b2); chk("R10 counter 2 stopped", {b2, b}, exp_cnt[2]);
    rd(8'h40, b); rd(8'h40, b2); chk("R10 counter 0 runs", {b2, b}, exp_cnt[0]);
    rd(8'h61, b); chk("R1 R10 gate readback", 16'(b), 16'h00);
    wr(8'h61, 8'h01); gate_m = 1'b1;
    ticks(2);
    rd(8'h42, b); rd(8'h42, b2); chk("R10 counter 2 resumes", {b2, b}, exp_cnt[2]);

    // R1 unmapped address
    rd(8'h50, b); chk("R1 unmapped", 16'(b), 16'h00);

    // R11 back-pressure
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h61;
    @(negedge clk);
    req_write = 1'b1; req_wdata = 8'h00;
    chk("R11 rsp_valid", 16'(rsp_valid), 16'h1);
    chk("R11 req_ready low", 16'(req_ready), 16'h0);
    b = rsp_data;
    repeat (2) @(negedge clk);
    chk("R11 data stable", 16'(rsp_data), 16'(b));
    chk("R11 still valid", 16'(rsp_valid), 16'h1);
    req_valid = 1'b0; req_write = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R11 released", 16'(rsp_valid), 16'h0);
    rd(8'h61, b); chk("R11 blocked write dropped", 16'(b), 16'h01);

    summary();
  end
endmodule